// File: doc/BRIEF.md
# PWM Timer Count-Enable Generator

This block produces the count-enable strobes for a bank of five PWM timers, all from one system clock. Two programmable 8-bit prescalers each divide the system clock. The first prescaler serves timers 0 and 1, and the second serves timers 2, 3 and 4. Each timer then divides its prescaler's tick by a power of two, or takes an external tick input in its place. Each output is a one-cycle enable pulse in the system clock domain, not a derived clock, so the timer counters that consume it stay on the same clock as everything else.

The block has two configuration words. The prescale word holds both 8-bit prescaler values. The select word holds one 4-bit code per timer, and that code sets both the divide ratio and the choice of the external source. Software writes one field at a time: each write names the word and the field index and carries the new value, so no other field can be disturbed. A read port returns either word whole. Because every control pin here is a plain level or strobe with no data stream, the block has no valid/ready handshake. A field write is accepted in the cycle `wr_en_i` is high and is never back-pressured.

Top module: `pwm_tick_tree`

## Requirements
- R1: While `rst_n` is low, every `tick_o` bit is 0. After reset, both configuration words read back as zero, which gives prescale 1 and divide-by-2 on every timer.
- R2: A prescaler with programmed value P produces one tick every P+1 system clocks. A new value takes effect at that prescaler's next reload.
- R3: Prescaler 0 drives timers 0 and 1 only. Prescaler 1 drives timers 2, 3 and 4 only.
- R4: A select code C from 0 to 3 gives a timer period of (P+1)·2^(C+1) system clocks. P is the value of that timer's prescaler, so the codes 0, 1, 2 and 3 divide the prescaler tick by 2, 4, 8 and 16.
- R5: A select code of 4 or above routes the external tick to the timer. Timers 0–1 use `ext_tick_i[0]` and timers 2–4 use `ext_tick_i[1]`. The input passes through a two-flop synchroniser, and each rising edge yields exactly one enable pulse.
- R6: A write changes only the named field. The prescale word keeps prescaler k in bits [8k+7:8k]. The select word keeps timer t's code in bits [4t+3:4t]. A write to a field index that does not exist changes nothing.
- R7: Every enable pulse lasts one system clock, unless the timer's select code changes between two consecutive pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick_i | input | 2 | External tick inputs, asynchronous; bit 0 serves timers 0–1 and bit 1 serves timers 2–4 |
| wr_en_i | input | 1 | Field write strobe |
| wr_kind_i | input | 1 | Target word: 0 prescale word, 1 select word |
| wr_idx_i | input | 3 | Field index: prescaler number or timer number |
| wr_val_i | input | 8 | New field value; only the low 4 bits are used for a select code |
| rd_kind_i | input | 1 | Word to read back: 0 prescale, 1 select |
| rd_data_o | output | 20 | Selected configuration word, zero-extended |
| tick_o | output | 5 | Per-timer one-cycle count-enable pulses |

## Verification
The assertions assume that `rst_n` is asserted at time zero and that the configuration changes only through the write port. The pulse-width property also depends on the external inputs: a synchronised rising edge cannot repeat on the very next clock, so the property cannot be stressed by an input that toggles every cycle. The stimulus holds each external level for four clocks. Random prescale values are kept small enough that several full periods fit into each trial, and directed cases cover the largest prescale and divide values and writes to field indices that do not exist.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  localparam int unsigned TMR_N     = 5;
  localparam int unsigned PRE_W     = 8;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned DIV_W     = 4;
  localparam int unsigned GRP0_SPAN = 2;

  typedef enum logic {
    CFG_PRESCALE = 1'b0,
    CFG_SELECT   = 1'b1
  } cfg_kind_e;

  function automatic int unsigned group_of(int unsigned tmr, int unsigned span);
    return (tmr < span) ? 0 : 1;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] reload_val,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  // Down-counter: the programmed value is sampled only when the count wraps.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == '0) begin
      cnt_q <= reload_val;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  localparam int unsigned LEN = STAGES + 1;
  logic [LEN-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
    end else begin
      shreg_q <= {shreg_q[LEN-2:0], async_in};
    end
  end

  // shreg_q[STAGES-1] is the synchronised level; the extra flop holds its history.
  assign rise_pulse = shreg_q[STAGES-1] & ~shreg_q[STAGES];
endmodule

// File: rtl/pwm_chan_div.sv
module pwm_chan_div #(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic             ext_pulse,
  input  logic [SEL_W-1:0] sel_code,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] ones_mask;
  logic             use_ext;
  logic             div_hit;

  assign use_ext = (sel_code >= SEL_W'(DIV_W));

  always_comb begin
    for (int b = 0; b < DIV_W; b++) begin
      ones_mask[b] = (SEL_W'(b) <= sel_code);
    end
  end

  assign div_hit = pre_tick && ((div_q & ones_mask) == ones_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      if (pre_tick) begin
        div_q <= div_q + 1'b1;
      end
      tick <= use_ext ? ext_pulse : div_hit;
    end
  end
endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
  parameter int unsigned TMR_N = 5,
  parameter int unsigned PRE_W = 8,
  parameter int unsigned SEL_W = 4,
  parameter int unsigned GRP_N = 2,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned RD_W  = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   wr_kind,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [PRE_W-1:0]       wr_val,
  input  logic                   rd_kind,
  output logic [RD_W-1:0]        rd_data,
  output logic [GRP_N*PRE_W-1:0] pre_word,
  output logic [TMR_N*SEL_W-1:0] sel_word
);
  import pwm_tick_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_word <= '0;
      sel_word <= '0;
    end else if (wr_en) begin
      if (wr_kind == CFG_PRESCALE) begin
        for (int g = 0; g < GRP_N; g++) begin
          if (wr_idx == IDX_W'(g)) begin
            pre_word[g*PRE_W +: PRE_W] <= wr_val;
          end
        end
      end else begin
        for (int t = 0; t < TMR_N; t++) begin
          if (wr_idx == IDX_W'(t)) begin
            sel_word[t*SEL_W +: SEL_W] <= wr_val[SEL_W-1:0];
          end
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_kind == CFG_PRESCALE) begin
      rd_data[GRP_N*PRE_W-1:0] = pre_word;
    end else begin
      rd_data[TMR_N*SEL_W-1:0] = sel_word;
    end
  end
endmodule

// File: rtl/pwm_tick_tree.sv
module pwm_tick_tree #(
  parameter int unsigned TMR_N     = pwm_tick_pkg::TMR_N,
  parameter int unsigned PRE_W     = pwm_tick_pkg::PRE_W,
  parameter int unsigned SEL_W     = pwm_tick_pkg::SEL_W,
  parameter int unsigned DIV_W     = pwm_tick_pkg::DIV_W,
  parameter int unsigned GRP0_SPAN = pwm_tick_pkg::GRP0_SPAN,
  localparam int unsigned GRP_N    = 2,
  localparam int unsigned IDX_W    = (TMR_N > 1) ? $clog2(TMR_N) : 1,
  localparam int unsigned RD_W     = (TMR_N*SEL_W > GRP_N*PRE_W) ? TMR_N*SEL_W : GRP_N*PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_N-1:0] ext_tick_i,
  input  logic             wr_en_i,
  input  logic             wr_kind_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PRE_W-1:0] wr_val_i,
  input  logic             rd_kind_i,
  output logic [RD_W-1:0]  rd_data_o,
  output logic [TMR_N-1:0] tick_o
);
  import pwm_tick_pkg::*;

  logic [GRP_N*PRE_W-1:0] pre_cfg;
  logic [TMR_N*SEL_W-1:0] sel_cfg;
  logic [GRP_N-1:0]       pre_tick;
  logic [GRP_N-1:0]       ext_pulse;

  pwm_cfg_regs #(
    .TMR_N(TMR_N), .PRE_W(PRE_W), .SEL_W(SEL_W),
    .GRP_N(GRP_N), .IDX_W(IDX_W), .RD_W(RD_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .wr_kind  (wr_kind_i),
    .wr_idx   (wr_idx_i),
    .wr_val   (wr_val_i),
    .rd_kind  (rd_kind_i),
    .rd_data  (rd_data_o),
    .pre_word (pre_cfg),
    .sel_word (sel_cfg)
  );

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload_val (pre_cfg[g*PRE_W +: PRE_W]),
      .tick       (pre_tick[g])
    );

    pwm_edge_sync #(.STAGES(2)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (ext_tick_i[g]),
      .rise_pulse (ext_pulse[g])
    );
  end

  for (genvar t = 0; t < TMR_N; t++) begin : g_tmr
    localparam int unsigned GRP = group_of(t, GRP0_SPAN);

    pwm_chan_div #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .pre_tick  (pre_tick[GRP]),
      .ext_pulse (ext_pulse[GRP]),
      .sel_code  (sel_cfg[t*SEL_W +: SEL_W]),
      .tick      (tick_o[t])
    );
  end
endmodule

// File: rtl/pwm_tick_tree_chk.sv
module pwm_tick_tree_chk #(
  parameter int unsigned TMR_N     = 5,
  parameter int unsigned PRE_W     = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned DIV_W     = 4,
  parameter int unsigned GRP0_SPAN = 2,
  parameter int unsigned IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en_i,
  input logic                 wr_kind_i,
  input logic [IDX_W-1:0]     wr_idx_i,
  input logic [TMR_N-1:0]     tick_o,
  input logic [2*PRE_W-1:0]   pre_cfg,
  input logic [TMR_N*SEL_W-1:0] sel_cfg,
  input logic [1:0]           pre_tick,
  input logic [1:0]           ext_pulse
);
  import pwm_tick_pkg::*;

  // R1: outputs held quiet while in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_quiet_in_reset_r1: assert (tick_o == '0)
        else $error("tick_o active during reset");
    end
  end

  // R6: a select-word write leaves the prescale word untouched
  p_pre_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_kind_i == CFG_SELECT) |=> (pre_cfg == $past(pre_cfg)));

  for (genvar t = 0; t < TMR_N; t++) begin : g_chk
    localparam int unsigned GRP = group_of(t, GRP0_SPAN);

    // R6: a field is only changed by a write that names it
    p_field_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && wr_kind_i == CFG_SELECT && wr_idx_i == IDX_W'(t))
      |=> $stable(sel_cfg[t*SEL_W +: SEL_W]));

    // R3, R4: a divided pulse needs a tick from this timer's own prescaler
    p_div_from_own_grp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o[t] && $past(sel_cfg[t*SEL_W +: SEL_W]) < SEL_W'(DIV_W))
      |-> $past(pre_tick[GRP]));

    // R5: an external selection follows the synchronised edge of its own input
    p_ext_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_cfg[t*SEL_W +: SEL_W]) >= SEL_W'(DIV_W))
      |-> (tick_o[t] == $past(ext_pulse[GRP])));

    // R7: single-cycle pulses while the select code holds
    p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o[t] && $stable(sel_cfg[t*SEL_W +: SEL_W])) |=> !tick_o[t]);
  end
endmodule

bind pwm_tick_tree pwm_tick_tree_chk #(
  .TMR_N(TMR_N), .PRE_W(PRE_W), .SEL_W(SEL_W), .DIV_W(DIV_W),
  .GRP0_SPAN(GRP0_SPAN), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en_i   (wr_en_i),
  .wr_kind_i (wr_kind_i),
  .wr_idx_i  (wr_idx_i),
  .tick_o    (tick_o),
  .pre_cfg   (pre_cfg),
  .sel_cfg   (sel_cfg),
  .pre_tick  (pre_tick),
  .ext_pulse (ext_pulse)
);

// File: tb/test_pwm_tick_tree.sv
module test_pwm_tick_tree;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_tick_i = '0;
  logic        wr_en_i = 1'b0;
  logic        wr_kind_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [7:0]  wr_val_i = '0;
  logic        rd_kind_i = 1'b0;
  logic [19:0] rd_data_o;
  logic [4:0]  tick_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] pre_sh [2];
  logic [3:0] sel_sh [NT];

  bit counting = 0;
  int pulse_cnt [NT];
  logic [4:0] prev_tick = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_tick_tree i_pwm_tick_tree (
    .clk(clk), .rst_n(rst_n), .ext_tick_i(ext_tick_i),
    .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i), .wr_idx_i(wr_idx_i),
    .wr_val_i(wr_val_i), .rd_kind_i(rd_kind_i),
    .rd_data_o(rd_data_o), .tick_o(tick_o)
  );

  function automatic int grp(int t);
    return (t < 2) ? 0 : 1;
  endfunction

  function automatic int exp_period(int t);
    return (int'(pre_sh[grp(t)]) + 1) << (int'(sel_sh[t]) + 1);
  endfunction

  function automatic logic [19:0] exp_word(bit kind);
    logic [19:0] w = '0;
    if (!kind) w[15:0] = {pre_sh[1], pre_sh[0]};
    else for (int t = 0; t < NT; t++) w[4*t +: 4] = sel_sh[t];
    return w;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(bit kind, int idx, int val);
    @(negedge clk);
    wr_en_i = 1'b1; wr_kind_i = kind; wr_idx_i = 3'(idx); wr_val_i = 8'(val);
    @(negedge clk);
    wr_en_i = 1'b0;
    if (!kind && idx < 2) pre_sh[idx] = 8'(val);
    if (kind && idx < NT) sel_sh[idx] = 4'(val);
  endtask

  task automatic check_readback(string req);
    for (int k = 0; k < 2; k++) begin
      rd_kind_i = k[0];
      #1;
      check(rd_data_o == exp_word(k[0]), req, int'(rd_data_o), int'(exp_word(k[0])));
    end
  endtask

  task automatic wait_tick(int t);
    do @(negedge clk); while (!tick_o[t]);
  endtask

  task automatic meas(int t, string req);
    int n;
    wait_tick(t);
    wait_tick(t);
    for (int r = 0; r < 2; r++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!tick_o[t]);
      check(n == exp_period(t), req, n, exp_period(t));
    end
  endtask

  task automatic meas_all(string req);
    for (int c = 0; c < NT; c++) begin
      automatic int cc = c;
      fork meas(cc, req); join_none
    end
    wait fork;
  endtask

  task automatic ext_edge(int g);
    ext_tick_i[g] = 1'b1;
    repeat (4) @(negedge clk);
    ext_tick_i[g] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // pulse counter and pulse-width watch for externally fed timers
  always @(negedge clk) begin
    if (counting) begin
      for (int t = 0; t < NT; t++) begin
        if (tick_o[t]) pulse_cnt[t]++;
        if (sel_sh[t] >= 4 && tick_o[t] && prev_tick[t]) begin
          fails++;
          $display("FAIL R7 timer %0d actual=2-cycle pulse expected=1", t);
        end
      end
    end
    prev_tick <= tick_o;
  end

  task automatic ext_window(int g, int edges, int exp_a [NT]);
    for (int t = 0; t < NT; t++) pulse_cnt[t] = 0;
    counting = 1;
    for (int e = 0; e < edges; e++) ext_edge(g);
    repeat (6) @(negedge clk);
    counting = 0;
    for (int t = 0; t < NT; t++)
      if (sel_sh[t] >= 4) check(pulse_cnt[t] == exp_a[t], "R5 ext pulses", pulse_cnt[t], exp_a[t]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int ea [NT];
    void'($urandom(32'd20240611));
    pre_sh[0] = '0; pre_sh[1] = '0;
    for (int t = 0; t < NT; t++) sel_sh[t] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(tick_o == '0, "R1 ticks in reset", int'(tick_o), 0);
    check_readback("R1 reset readback");
    rst_n = 1'b1;

    // R1, R4: default configuration gives period 2 everywhere
    meas_all("R1 default period");

    // R2, R3, R4: distinct prescalers and all divide codes
    wr(0, 0, 3); wr(0, 1, 9);
    wr(1, 0, 0); wr(1, 1, 3); wr(1, 2, 1); wr(1, 3, 2); wr(1, 4, 3);
    check_readback("R6 readback directed");
    meas_all("R3 group routing");

    // R2, R4: largest prescale and divide
    wr(0, 1, 255); wr(0, 0, 0);
    wr(1, 0, 2); wr(1, 1, 1); wr(1, 2, 0); wr(1, 3, 1); wr(1, 4, 3);
    meas_all("R2 max prescale");

    // R6: single-field writes and nonexistent indices
    wr(1, 2, 9);
    check_readback("R6 one field");
    wr(1, 5, 15); wr(1, 7, 15); wr(0, 2, 8'hAA); wr(0, 7, 8'h55);
    check_readback("R6 bad index");

    // R2, R4: random configurations
    for (int k = 0; k < 8; k++) begin
      wr(0, $urandom_range(0, 1), $urandom_range(0, 15));
      wr(0, $urandom_range(0, 1), $urandom_range(0, 15));
      for (int t = 0; t < NT; t++) wr(1, t, $urandom_range(0, 3));
      check_readback("R6 random readback");
      meas_all("R4 random period");
    end

    // R5, R7: external sources
    wr(0, 0, 0); wr(0, 1, 0);
    wr(1, 0, 4); wr(1, 1, 0); wr(1, 2, 5); wr(1, 3, 1); wr(1, 4, 15);
    repeat (8) @(negedge clk);
    ea = '{5, 0, 0, 0, 0};
    ext_window(0, 5, ea);
    ea = '{0, 0, 3, 0, 3};
    ext_window(1, 3, ea);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule